// File: doc/BRIEF.md
# Buffer Pointer Unit

This block holds the two host-side pointers into an 8 KB byte buffer: a read pointer and a write pointer, each 13 bits wide. A register interface loads either pointer and sets an auto-increment enable. When a host read or write strobe arrives, the block presents the RAM address for that byte access. If auto-increment is on, the matching pointer then steps to the next location.

The read pointer and the write pointer follow different stepping rules. A read that leaves the last byte of the programmable receive ring lands on the first byte of the ring. A write always steps linearly and ignores the ring. Both pointers roll from 1FFFh to 0000h by plain 13-bit overflow. The same stepping rules are offered to a DMA engine through a combinational advance port. The DMA engine supplies its current read and write positions and receives the next ones. The DMA engine keeps its own pointers.

There is no sequencing state in the block; all behaviour is per-cycle register update.

Top module: `bufptr_unit`

## Requirements
- R1: After reset the read pointer and the write pointer are 0000h and the auto-increment enable is 1.
- R2: With auto-increment at 1, a host read strobe moves the read pointer to the next location at the following clock edge.
- R3: With auto-increment at 1, a host write strobe moves the write pointer up by one at the following clock edge.
- R4: With auto-increment at 0, host read and write strobes leave both pointers unchanged.
- R5: A read step taken from the pointer value equal to `rx_end` yields `rx_start`.
- R6: A write step never wraps at `rx_end`; from `rx_end` it yields `rx_end`+1.
- R7: A step from 1FFFh yields 0000h for the write pointer, and also for the read pointer when 1FFFh is not `rx_end`.
- R8: A pointer load in the same cycle as a strobe on that pointer wins; the pointer takes the loaded value.
- R9: During a strobe cycle, `host_rd_addr` and `host_wr_addr` carry the pointer value from before the step.
- R10: In the same cycle, `dma_rd_nxt` gives the read-rule step of `dma_rd_cur` (wrapping at `rx_end`), and `dma_wr_nxt` gives the linear step of `dma_wr_cur`.
- R11: A write of the enable (`cfg_ai_we`) sets `autoinc` to `cfg_ai_val` at the next clock edge.
- R12: With a ring that crosses 1FFFh (`rx_start` > `rx_end`), the read pointer steps 1FFFh to 0000h inside the ring and steps from `rx_end` back to `rx_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rd_ld | input | 1 | Load the read pointer from `cfg_ptr_val` |
| cfg_wr_ld | input | 1 | Load the write pointer from `cfg_ptr_val` |
| cfg_ptr_val | input | 13 | Value for pointer loads |
| cfg_ai_we | input | 1 | Write the auto-increment enable |
| cfg_ai_val | input | 1 | New auto-increment enable value |
| host_rd_stb | input | 1 | Host byte read from the buffer this cycle |
| host_wr_stb | input | 1 | Host byte write to the buffer this cycle |
| rx_start | input | 13 | First byte of the receive ring |
| rx_end | input | 13 | Last byte of the receive ring |
| dma_rd_cur | input | 13 | DMA read position |
| dma_wr_cur | input | 13 | DMA write position |
| dma_rd_nxt | output | 13 | DMA read position after one step (ring rule) |
| dma_wr_nxt | output | 13 | DMA write position after one step (linear rule) |
| host_rd_addr | output | 13 | RAM address of the host read |
| host_wr_addr | output | 13 | RAM address of the host write |
| rd_ptr | output | 13 | Current read pointer |
| wr_ptr | output | 13 | Current write pointer |
| autoinc | output | 1 | Current auto-increment enable |

## Verification
The bench walks both pointers onto `rx_end` in the same cycles. A design that shared one stepping rule would send the write pointer back to `rx_start`, or would let the read pointer run past the ring. It steps both pointers from 1FFFh, both in a ring that ends elsewhere and in a ring that crosses 1FFFh. A wrong wrap compare or a missing overflow would show there as a jump to `rx_start`, or as an out-of-range address. It raises a load and a strobe together, which catches an increment given priority over the load. It samples the address during the strobe cycle, which catches a design that issues the post-step address.

// File: rtl/bufptr_pkg.sv
`timescale 1ns/1ps
package bufptr_pkg;
    localparam int PTR_W = 13;

    typedef enum logic {
        STEP_LINEAR = 1'b0,
        STEP_RING   = 1'b1
    } step_mode_e;
endpackage

// File: rtl/bufptr_step.sv
`timescale 1ns/1ps
module bufptr_step
    import bufptr_pkg::*;
#(
    parameter int         W    = PTR_W,
    parameter step_mode_e MODE = STEP_LINEAR
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] ring_start,
    input  logic [W-1:0] ring_end,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic at_end;

    always_comb begin
        at_end = (cur == ring_end);
        if ((MODE == STEP_RING) && at_end) begin
            nxt = ring_start;
        end else begin
            nxt = cur + ONE;
        end
    end
endmodule

// File: rtl/bufptr_reg.sv
`timescale 1ns/1ps
module bufptr_reg #(
    parameter int           W         = 13,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         adv,
    input  logic [W-1:0] adv_val,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (ld) begin
            q <= ld_val;
        end else if (adv) begin
            q <= adv_val;
        end
    end

    // R8: a load beats any concurrent advance
    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (q == $past(ld_val)));

    // R4: with neither load nor advance the register holds
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv) |=> $stable(q));
endmodule

// File: rtl/bufptr_unit.sv
`timescale 1ns/1ps
module bufptr_unit
    import bufptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_rd_ld,
    input  logic             cfg_wr_ld,
    input  logic [PTR_W-1:0] cfg_ptr_val,
    input  logic             cfg_ai_we,
    input  logic             cfg_ai_val,
    input  logic             host_rd_stb,
    input  logic             host_wr_stb,
    input  logic [PTR_W-1:0] rx_start,
    input  logic [PTR_W-1:0] rx_end,
    input  logic [PTR_W-1:0] dma_rd_cur,
    input  logic [PTR_W-1:0] dma_wr_cur,
    output logic [PTR_W-1:0] dma_rd_nxt,
    output logic [PTR_W-1:0] dma_wr_nxt,
    output logic [PTR_W-1:0] host_rd_addr,
    output logic [PTR_W-1:0] host_wr_addr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             autoinc
);
    localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

    logic [PTR_W-1:0] rd_step;
    logic [PTR_W-1:0] wr_step;
    logic             rd_adv;
    logic             wr_adv;

    // Stepping rules: ring for reads, linear for writes (host and DMA)
    bufptr_step #(.W(PTR_W), .MODE(STEP_RING)) u_host_rd_step (
        .cur(rd_ptr), .ring_start(rx_start), .ring_end(rx_end), .nxt(rd_step));
    bufptr_step #(.W(PTR_W), .MODE(STEP_LINEAR)) u_host_wr_step (
        .cur(wr_ptr), .ring_start(rx_start), .ring_end(rx_end), .nxt(wr_step));
    bufptr_step #(.W(PTR_W), .MODE(STEP_RING)) u_dma_rd_step (
        .cur(dma_rd_cur), .ring_start(rx_start), .ring_end(rx_end), .nxt(dma_rd_nxt));
    bufptr_step #(.W(PTR_W), .MODE(STEP_LINEAR)) u_dma_wr_step (
        .cur(dma_wr_cur), .ring_start(rx_start), .ring_end(rx_end), .nxt(dma_wr_nxt));

    always_comb begin
        rd_adv       = host_rd_stb && autoinc;
        wr_adv       = host_wr_stb && autoinc;
        host_rd_addr = rd_ptr;
        host_wr_addr = wr_ptr;
    end

    bufptr_reg #(.W(PTR_W), .RESET_VAL('0)) u_rd_reg (
        .clk(clk), .rst_n(rst_n), .ld(cfg_rd_ld), .ld_val(cfg_ptr_val),
        .adv(rd_adv), .adv_val(rd_step), .q(rd_ptr));

    bufptr_reg #(.W(PTR_W), .RESET_VAL('0)) u_wr_reg (
        .clk(clk), .rst_n(rst_n), .ld(cfg_wr_ld), .ld_val(cfg_ptr_val),
        .adv(wr_adv), .adv_val(wr_step), .q(wr_ptr));

    bufptr_reg #(.W(1), .RESET_VAL(1'b1)) u_ai_reg (
        .clk(clk), .rst_n(rst_n), .ld(cfg_ai_we), .ld_val(cfg_ai_val),
        .adv(1'b0), .adv_val(1'b0), .q(autoinc));

    // R5: a read step from the ring end lands on the ring start
    a_r5_rd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_stb && autoinc && !cfg_rd_ld && (rd_ptr == rx_end))
        |=> (rd_ptr == $past(rx_start)));

    // R3 / R6: write steps are always linear
    a_r6_wr_linear: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_stb && autoinc && !cfg_wr_ld)
        |=> (wr_ptr == $past(wr_ptr) + ONE));

    // R4: disabled auto-increment freezes the read pointer
    a_r4_rd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!autoinc && !cfg_rd_ld) |=> $stable(rd_ptr));

    // R11: the enable follows its write
    a_r11_ai_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ai_we |=> (autoinc == $past(cfg_ai_val)));
endmodule

// File: tb/test_bufptr_unit.sv
`timescale 1ns/1ps
module test_bufptr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rd_ld = 1'b0, cfg_wr_ld = 1'b0, cfg_ai_we = 1'b0, cfg_ai_val = 1'b0;
    logic [12:0] cfg_ptr_val = '0;
    logic        host_rd_stb = 1'b0, host_wr_stb = 1'b0;
    logic [12:0] rx_start = '0, rx_end = '0, dma_rd_cur = '0, dma_wr_cur = '0;
    logic [12:0] dma_rd_nxt, dma_wr_nxt, host_rd_addr, host_wr_addr, rd_ptr, wr_ptr;
    logic        autoinc;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bufptr_unit i_bufptr_unit (
        .clk(clk), .rst_n(rst_n), .cfg_rd_ld(cfg_rd_ld), .cfg_wr_ld(cfg_wr_ld),
        .cfg_ptr_val(cfg_ptr_val), .cfg_ai_we(cfg_ai_we), .cfg_ai_val(cfg_ai_val),
        .host_rd_stb(host_rd_stb), .host_wr_stb(host_wr_stb),
        .rx_start(rx_start), .rx_end(rx_end), .dma_rd_cur(dma_rd_cur), .dma_wr_cur(dma_wr_cur),
        .dma_rd_nxt(dma_rd_nxt), .dma_wr_nxt(dma_wr_nxt),
        .host_rd_addr(host_rd_addr), .host_wr_addr(host_wr_addr),
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .autoinc(autoinc));

    // flags {rd_ld, wr_ld, ai_we, ai_val, rd_stb, wr_stb}, load value, ring start,
    // ring end, expected rd_ptr, expected wr_ptr, expected autoinc
    localparam int NV = 18;
    localparam logic [71:0] VEC [NV] = '{
        {6'b100000, 13'h1002, 13'h1000, 13'h1003, 13'h1002, 13'h0000, 1'b1},
        {6'b010000, 13'h1002, 13'h1000, 13'h1003, 13'h1002, 13'h1002, 1'b1},
        {6'b000010, 13'h0000, 13'h1000, 13'h1003, 13'h1003, 13'h1002, 1'b1},
        {6'b000011, 13'h0000, 13'h1000, 13'h1003, 13'h1000, 13'h1003, 1'b1},
        {6'b000001, 13'h0000, 13'h1000, 13'h1003, 13'h1000, 13'h1004, 1'b1},
        {6'b001000, 13'h0000, 13'h1000, 13'h1003, 13'h1000, 13'h1004, 1'b0},
        {6'b000011, 13'h0000, 13'h1000, 13'h1003, 13'h1000, 13'h1004, 1'b0},
        {6'b001100, 13'h0000, 13'h1000, 13'h1003, 13'h1000, 13'h1004, 1'b1},
        {6'b110000, 13'h1FFF, 13'h1000, 13'h1003, 13'h1FFF, 13'h1FFF, 1'b1},
        {6'b000011, 13'h0000, 13'h1000, 13'h1003, 13'h0000, 13'h0000, 1'b1},
        {6'b100010, 13'h0005, 13'h1000, 13'h1003, 13'h0005, 13'h0000, 1'b1},
        {6'b010001, 13'h0009, 13'h1000, 13'h1003, 13'h0005, 13'h0009, 1'b1},
        {6'b100000, 13'h1FFF, 13'h1FFE, 13'h0001, 13'h1FFF, 13'h0009, 1'b1},
        {6'b000010, 13'h0000, 13'h1FFE, 13'h0001, 13'h0000, 13'h0009, 1'b1},
        {6'b000010, 13'h0000, 13'h1FFE, 13'h0001, 13'h0001, 13'h0009, 1'b1},
        {6'b000010, 13'h0000, 13'h1FFE, 13'h0001, 13'h1FFE, 13'h0009, 1'b1},
        {6'b010000, 13'h0001, 13'h1FFE, 13'h0001, 13'h1FFE, 13'h0001, 1'b1},
        {6'b000001, 13'h0000, 13'h1FFE, 13'h0001, 13'h1FFE, 13'h0002, 1'b1}
    };
    localparam string TAGS [NV] = '{
        "R8 load rd", "R8 load wr", "R2 rd step", "R5/R3 rd wrap, wr step",
        "R6 wr past rx_end", "R11 ai off", "R4 no step", "R11 ai on",
        "R8 load both", "R7 overflow", "R8 rd load wins", "R8 wr load wins",
        "R12 load", "R12 rd 1FFF->0", "R12 rd step", "R12 rd wrap",
        "R6 load", "R6 wr past ring end"};

    task automatic check13(input string tag, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check13("R1 rd_ptr reset", rd_ptr, 13'h0000);
        check13("R1 wr_ptr reset", wr_ptr, 13'h0000);
        check13("R1 autoinc reset", {12'd0, autoinc}, 13'h0001);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            {cfg_rd_ld, cfg_wr_ld, cfg_ai_we, cfg_ai_val, host_rd_stb, host_wr_stb} = VEC[i][71:66];
            cfg_ptr_val = VEC[i][65:53];
            rx_start    = VEC[i][52:40];
            rx_end      = VEC[i][39:27];
            @(posedge clk);
            @(negedge clk);
            {cfg_rd_ld, cfg_wr_ld, cfg_ai_we, cfg_ai_val, host_rd_stb, host_wr_stb} = '0;
            check13({TAGS[i], " rd_ptr"}, rd_ptr, VEC[i][26:14]);
            check13({TAGS[i], " wr_ptr"}, wr_ptr, VEC[i][13:1]);
            check13({TAGS[i], " autoinc"}, {12'd0, autoinc}, {12'd0, VEC[i][0]});
        end

        // R9: address during the strobe is the pre-step pointer
        cfg_ptr_val = 13'h0ABC; cfg_rd_ld = 1'b1; cfg_wr_ld = 1'b1;
        @(posedge clk); @(negedge clk);
        cfg_rd_ld = 1'b0; cfg_wr_ld = 1'b0;
        host_rd_stb = 1'b1; host_wr_stb = 1'b1;
        #1;
        check13("R9 rd addr in strobe cycle", host_rd_addr, 13'h0ABC);
        check13("R9 wr addr in strobe cycle", host_wr_addr, 13'h0ABC);
        @(posedge clk); @(negedge clk);
        host_rd_stb = 1'b0; host_wr_stb = 1'b0;
        check13("R2 rd after strobe", rd_ptr, 13'h0ABD);
        check13("R3 wr after strobe", wr_ptr, 13'h0ABD);

        // R10: DMA advance port
        rx_start = 13'h1000; rx_end = 13'h1003;
        dma_rd_cur = 13'h1003; dma_wr_cur = 13'h1003; #1;
        check13("R10 dma rd wrap", dma_rd_nxt, 13'h1000);
        check13("R10 dma wr linear", dma_wr_nxt, 13'h1004);
        dma_rd_cur = 13'h1001; dma_wr_cur = 13'h1FFF; #1;
        check13("R10 dma rd step", dma_rd_nxt, 13'h1002);
        check13("R10 dma wr overflow", dma_wr_nxt, 13'h0000);
        dma_rd_cur = 13'h1FFF; #1;
        check13("R10 dma rd overflow outside ring", dma_rd_nxt, 13'h0000);

        finish_run();
    end
endmodule